// File: doc/BRIEF.md
# Coax Link Power-Up and Detach Supervisor

This block decides when a coaxial transceiver may run and when it must stay quiet. It holds both squelch paths closed while the supply is low. Once the supply becomes valid, it waits a fixed number of millisecond ticks before it releases them. It also watches a digitised, already-synchronised flag that reports a missing cable. When that flag has stayed high for longer than the detach window, the block closes the squelch paths and puts the station-side line drivers into high impedance. With the drivers floating, another transceiver wired to the same station port can take over.

When the cable is declared detached, the block raises a collision request for a fixed announcement window, unless the announcement option is turned off. When the cable returns, the block re-enables the link at once and makes no announcement. All intervals are measured in ticks of an external 1 ms strobe. The tick counts are parameters, so a test can use short intervals.

Top module: `coax_link_supervisor`

## Requirements
- R1: While reset is high, and on the first cycle after it, the outputs are force_squelch=1, drv_hiz=0, coll_req=0.
- R2: A clock edge that samples supply_ok=0 sets force_squelch=1, drv_hiz=0 and coll_req=0. It also restarts the power-up wait from zero ticks, whatever state the block was in.
- R3: After supply_ok returns, force_squelch falls on the edge that samples the PWR_TICKS-th ms_tick seen with supply_ok high. Until then coll_req stays 0, even if cable_open is high.
- R4: In the running state, the block declares a detach on the edge that samples the (OPEN_TICKS+1)-th consecutive ms_tick with cable_open high. From that edge on, force_squelch=1 and drv_hiz=1.
- R5: If cable_open is sampled low before the detach is declared, the filter count returns to zero. A later detach then needs a full OPEN_TICKS+1 ticks again.
- R6: With announce_off=0, coll_req rises on the detach edge. It falls on the edge that samples the ANN_TICKS-th ms_tick after that edge, and stays low while the cable remains detached.
- R7: On any edge that samples announce_off=1, coll_req becomes 0.
- R8: While detached, an edge that samples cable_open=0 returns the block to running: force_squelch=0, drv_hiz=0 and coll_req=0, with no announcement.
- R9: coll_req is high only while drv_hiz is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ms_tick | input | 1 | One-cycle strobe, once per millisecond |
| supply_ok | input | 1 | High when the supply is above the undervoltage threshold |
| cable_open | input | 1 | High when the comparator sees the cable missing |
| announce_off | input | 1 | High disables the collision announcement on detach |
| force_squelch | output | 1 | Holds the transmit and receive squelch closed |
| drv_hiz | output | 1 | Puts the station-side drivers into high impedance |
| coll_req | output | 1 | Requests the collision signal on the station port |

## Verification
A counter that is off by one shows as force_squelch or drv_hiz changing one tick early or late. The bench sweeps every glitch length and every restart point, so it sees such an error on the very tick it happens. A state register left in the wrong state shows within one clock edge: a float or a collision request after a supply drop or a reconnect. A stale announcement counter shows as coll_req lasting the wrong number of ticks on a repeated detach.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    ST_WAIT   = 2'd0,
    ST_LIVE   = 2'd1,
    ST_DETACH = 2'd2
  } sup_state_e;
endpackage

// File: rtl/sup_ms_counter.sv
// Saturating tick counter with synchronous clear.
// last: the current enabled tick is the one that reaches LIMIT.
module sup_ms_counter #(
  parameter int LIMIT = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick_en,
  output logic last,
  output logic full
);
  localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM_V  = W'(LIMIT);
  localparam logic [W-1:0] LAST_V = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (tick_en && (cnt_q != LIM_V)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last = tick_en && !clr && (cnt_q == LAST_V);
  assign full = (cnt_q == LIM_V);
endmodule

// File: rtl/sup_ctrl_fsm.sv
module sup_ctrl_fsm
  import sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       supply_ok,
  input  logic       cable_open,
  input  logic       announce_off,
  input  logic       pw_last,
  input  logic       open_last,
  input  logic       ann_last,
  input  logic       ann_full,
  output sup_state_e state_q,
  output logic       force_squelch,
  output logic       drv_hiz,
  output logic       coll_req
);
  sup_state_e state_d;
  logic       coll_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WAIT:   if (pw_last)     state_d = ST_LIVE;
      ST_LIVE:   if (open_last)   state_d = ST_DETACH;
      ST_DETACH: if (!cable_open) state_d = ST_LIVE;
      default:                    state_d = ST_WAIT;
    endcase
    if (!supply_ok) state_d = ST_WAIT;
  end

  // The announcement runs while the next state is detached and its window is not spent.
  assign coll_d = (state_d == ST_DETACH) && !announce_off &&
                  !((state_q == ST_DETACH) && (ann_full || ann_last));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_WAIT;
      force_squelch <= 1'b1;
      drv_hiz       <= 1'b0;
      coll_req      <= 1'b0;
    end else begin
      state_q       <= state_d;
      force_squelch <= (state_d != ST_LIVE);
      drv_hiz       <= (state_d == ST_DETACH);
      coll_req      <= coll_d;
    end
  end
endmodule

// File: rtl/coax_link_supervisor.sv
module coax_link_supervisor
  import sup_pkg::*;
#(
  parameter int PWR_TICKS  = 400,
  parameter int OPEN_TICKS = 800,
  parameter int ANN_TICKS  = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic ms_tick,
  input  logic supply_ok,
  input  logic cable_open,
  input  logic announce_off,
  output logic force_squelch,
  output logic drv_hiz,
  output logic coll_req
);
  sup_state_e state_q;
  logic pw_last, pw_full;
  logic open_last, open_full;
  logic ann_last, ann_full;

  // power-up wait: runs only in the wait state with a good supply
  sup_ms_counter #(.LIMIT(PWR_TICKS)) pw_cnt_i (
    .clk(clk), .rst(rst),
    .clr((state_q != ST_WAIT) || !supply_ok),
    .tick_en(ms_tick),
    .last(pw_last), .full(pw_full)
  );

  // detach filter: strictly longer than OPEN_TICKS
  sup_ms_counter #(.LIMIT(OPEN_TICKS + 1)) open_cnt_i (
    .clk(clk), .rst(rst),
    .clr((state_q != ST_LIVE) || !cable_open || !supply_ok),
    .tick_en(ms_tick),
    .last(open_last), .full(open_full)
  );

  // announcement window
  sup_ms_counter #(.LIMIT(ANN_TICKS)) ann_cnt_i (
    .clk(clk), .rst(rst),
    .clr(state_q != ST_DETACH),
    .tick_en(ms_tick),
    .last(ann_last), .full(ann_full)
  );

  sup_ctrl_fsm fsm_i (
    .clk(clk), .rst(rst),
    .supply_ok(supply_ok), .cable_open(cable_open), .announce_off(announce_off),
    .pw_last(pw_last), .open_last(open_last),
    .ann_last(ann_last), .ann_full(ann_full),
    .state_q(state_q),
    .force_squelch(force_squelch), .drv_hiz(drv_hiz), .coll_req(coll_req)
  );

  logic unused_full;
  assign unused_full = pw_full ^ open_full;
endmodule

// File: rtl/sup_checker.sv
module sup_checker (
  input logic clk,
  input logic rst,
  input logic supply_ok,
  input logic cable_open,
  input logic announce_off,
  input logic force_squelch,
  input logic drv_hiz,
  input logic coll_req
);
  // R2
  supply_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> (force_squelch && !drv_hiz && !coll_req));
  // R3
  wait_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (force_squelch && !drv_hiz) |-> !coll_req);
  // R4
  float_squelch_chk: assert property (@(posedge clk) disable iff (rst)
    drv_hiz |-> force_squelch);
  // R7
  ann_off_chk: assert property (@(posedge clk) disable iff (rst)
    announce_off |=> !coll_req);
  // R8
  reconnect_chk: assert property (@(posedge clk) disable iff (rst)
    !cable_open |=> !drv_hiz);
  // R9
  coll_float_chk: assert property (@(posedge clk) disable iff (rst)
    coll_req |-> drv_hiz);
endmodule

bind coax_link_supervisor sup_checker sup_checker_i (
  .clk(clk), .rst(rst), .supply_ok(supply_ok), .cable_open(cable_open),
  .announce_off(announce_off), .force_squelch(force_squelch),
  .drv_hiz(drv_hiz), .coll_req(coll_req)
);

// File: tb/coax_link_supervisor_tb_top.sv
module coax_link_supervisor_tb_top;
  localparam int PW  = 4;
  localparam int OPN = 6;
  localparam int ANN = 3;
  localparam logic [2:0] Q_SQ   = 3'b100; // {force_squelch, drv_hiz, coll_req}
  localparam logic [2:0] Q_RUN  = 3'b000;
  localparam logic [2:0] Q_FLT  = 3'b110;
  localparam logic [2:0] Q_ANN  = 3'b111;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ms_tick = 1'b0, supply_ok = 1'b0, cable_open = 1'b0, announce_off = 1'b0;
  logic force_squelch, drv_hiz, coll_req;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  coax_link_supervisor #(.PWR_TICKS(PW), .OPEN_TICKS(OPN), .ANN_TICKS(ANN)) dut_i (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .supply_ok(supply_ok),
    .cable_open(cable_open), .announce_off(announce_off),
    .force_squelch(force_squelch), .drv_hiz(drv_hiz), .coll_req(coll_req)
  );

  task automatic chk(input string req, input logic [2:0] exp);
    total++;
    if ({force_squelch, drv_hiz, coll_req} !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b at %0t", req, {force_squelch, drv_hiz, coll_req}, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk); ms_tick = 1'b1;
    @(negedge clk); ms_tick = 1'b0;
  endtask

  // run from power-up wait into the running state
  task automatic power_up();
    for (int t = 1; t <= PW; t++) begin
      tick();
      chk("R3", (t < PW) ? Q_SQ : Q_RUN);
    end
  endtask

  // from running, open the cable and count to the detach point
  task automatic detach(input logic [2:0] at_decl);
    cable_open = 1'b1;
    for (int t = 1; t <= OPN + 1; t++) begin
      tick();
      chk("R4", (t <= OPN) ? Q_RUN : at_decl);
    end
  endtask

  task automatic reconnect();
    cable_open = 1'b0;
    step();
    chk("R8", Q_RUN);
  endtask

  initial begin
    step(); step();
    chk("R1", Q_SQ);
    rst = 1'b0;
    step();
    chk("R1", Q_SQ);
    // ticks with a low supply do nothing
    for (int t = 0; t < PW + 2; t++) begin tick(); chk("R2", Q_SQ); end
    // power-up with the cable missing: no announcement, no float
    cable_open = 1'b1;
    supply_ok = 1'b1;
    power_up();
    // filter starts fresh in the running state
    detach(Q_ANN);
    reconnect();

    // supply-drop restart sweep
    for (int k = 0; k < PW; k++) begin
      supply_ok = 1'b0; step(); chk("R2", Q_SQ);
      supply_ok = 1'b1;
      for (int t = 0; t < k; t++) begin tick(); chk("R3", Q_SQ); end
      supply_ok = 1'b0; step(); chk("R2", Q_SQ);
      supply_ok = 1'b1;
      power_up();
    end

    // glitch sweep on the detach filter
    for (int g = 1; g <= OPN; g++) begin
      cable_open = 1'b1;
      for (int t = 0; t < g; t++) begin tick(); chk("R5", Q_RUN); end
      cable_open = 1'b0; step(); chk("R5", Q_RUN);
      detach(Q_ANN);
      reconnect();
    end

    // announcement length, reconnect at every point of the window
    for (int j = 0; j <= ANN + 1; j++) begin
      detach(Q_ANN);
      for (int t = 1; t <= j; t++) begin
        tick();
        chk("R6", (t < ANN) ? Q_ANN : Q_FLT);
      end
      reconnect();
    end

    // announcement disabled
    announce_off = 1'b1;
    detach(Q_FLT);
    for (int t = 0; t < ANN + 1; t++) begin tick(); chk("R7", Q_FLT); end
    reconnect();
    // disabled in the middle of a window
    announce_off = 1'b0;
    detach(Q_ANN);
    announce_off = 1'b1; step(); chk("R7", Q_FLT);
    announce_off = 1'b0; step(); chk("R9", Q_ANN);
    reconnect();

    // supply drop while detached
    detach(Q_ANN);
    supply_ok = 1'b0; step(); chk("R2", Q_SQ);
    supply_ok = 1'b1;
    power_up();
    cable_open = 1'b0; step(); chk("R8", Q_RUN);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule